// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves translation-buffer misses without software help. A requester presents a virtual page number. The walker forms the address of the matching entry in a single-level page table: the table base plus the page number scaled by the 4-byte entry size. It reads that word over a valid/ready memory port and inspects the entry's present bit. A present entry is handed back for a translation-buffer fill, after which the requester retries its access. An absent entry produces a page-fault pulse instead.

The same request port also carries reference/dirty updates. For an update, the walker reads the entry, ORs the requested status bits into it, and writes the word back to the same address. An update aimed at an absent entry is reported as a fault and nothing is written. Pages are 4 KiB, so a page number is the address above bit 11. The walker handles one request at a time and reports `busy` until that request is finished.

Top module: `ptw_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `mem_req_valid`, `fill_valid`, `fault_valid` and `upd_done` are all low.
- R2: Every memory request for a request with page number V targets address `base + 4*V`, computed modulo 2^PA_W. The base is the value of `ptbr` in the cycle the request was accepted. The read uses `mem_req_we` = 0.
- R3: A memory request stays asserted, with unchanged address, write flag and data, until `mem_req_ready` is seen high. After a read is accepted, the walker waits any number of cycles for `mem_rsp_valid`.
- R4: When a walk reads an entry whose bit 31 (present) is 1, `fill_valid` pulses for one cycle. During that pulse `out_vpn` equals the requested page number, `out_pte` equals the whole 32-bit entry, and `out_ppn` equals its bits 19:0.
- R5: When a walk or an update reads an entry whose bit 31 is 0, `fault_valid` pulses for one cycle with `out_vpn` set to the requested page number, and no fill is produced.
- R6: `busy` is high from the cycle after a request is accepted until the request finishes. A `req_valid` raised while `busy` is high is ignored: it produces no memory access and no outcome.
- R7: An update of a present entry writes back the word read, with bit 30 (reference) ORed with `req_set_ref` and bit 29 (dirty) ORed with `req_set_dirty`. All other bits are unchanged, and `upd_done` pulses for one cycle afterwards. An update of an absent entry writes nothing.
- R8: Each accepted request yields exactly one of `fill_valid`, `fault_valid` or `upd_done`. `busy` is low in the cycle after that pulse.
- R9: A walk issues exactly one memory read and no write. An update of a present entry issues exactly one read followed by exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | PA_W | Page table base address |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_upd | input | 1 | 0 = walk for a fill, 1 = status-bit update |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_set_ref | input | 1 | Update: set the reference bit |
| req_set_dirty | input | 1 | Update: set the dirty bit |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_wdata | output | 32 | Write data (updated entry) |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after the read handshake |
| mem_rsp_rdata | input | 32 | Read data |
| fill_valid | output | 1 | One-cycle pulse: entry present, fill the translation buffer |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| upd_done | output | 1 | One-cycle pulse: update written back |
| out_vpn | output | VPN_W | Page number of the finishing request |
| out_pte | output | 32 | Entry read for the finishing request |
| out_ppn | output | PPN_W | Physical page number field of `out_pte` |

## Verification
The bench builds the walker with VPN_W = 20, PA_W = 32 and PPN_W = 20. The full-width page number 0xFFFFE can then be paired with a base near the top of the address space, which drives the scaled-sum address through its wraparound. The memory model holds each request off for a programmable number of cycles and returns data after a programmable latency. This exposes request holding and open-ended response waiting. Repeated updates of one entry, each followed by a walk that reads it back, show that the ORed status bits accumulate while the frame number is kept.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry word layout; the walker decodes these positions
    localparam int PTE_W     = 32;
    localparam int PTE_PRES  = 31;
    localparam int PTE_REF   = 30;
    localparam int PTE_DIRTY = 29;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_REQ   = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_CHECK    = 3'd3,
        ST_FILL     = 3'd4,
        ST_FAULT    = 3'd5,
        ST_WR_REQ   = 3'd6,
        ST_UPD_DONE = 3'd7
    } ptw_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W        = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [PA_W-1:0] offset;

    always_comb begin
        offset = PA_W'(vpn) << SHIFT;
        addr   = base + offset;
    end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
#(
    parameter int PPN_W = 20
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             set_ref,
    input  logic             set_dirty,
    output logic             present,
    output logic [PPN_W-1:0] ppn,
    output logic [PTE_W-1:0] merged
);
    always_comb begin
        present           = pte[PTE_PRES];
        ppn               = pte[PPN_W-1:0];
        merged            = pte;
        merged[PTE_REF]   = pte[PTE_REF] | set_ref;
        merged[PTE_DIRTY] = pte[PTE_DIRTY] | set_dirty;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    input  logic             req_upd,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_set_ref,
    input  logic             req_set_dirty,
    input  logic             entry_present,
    input  logic [PTE_W-1:0] merged_pte,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_rdata,
    output logic [PA_W-1:0]  base_q,
    output logic [VPN_W-1:0] vpn_q,
    output logic [PTE_W-1:0] pte_q,
    output logic             set_ref_q,
    output logic             set_dirty_q,
    output logic             mem_req_valid,
    output logic             mem_req_we,
    output logic [PTE_W-1:0] mem_req_wdata,
    output logic             busy,
    output logic             fill_valid,
    output logic             fault_valid,
    output logic             upd_done
);
    typedef struct packed {
        ptw_state_e       st;
        logic             is_upd;
        logic             set_ref;
        logic             set_dirty;
        logic [PA_W-1:0]  base;
        logic [VPN_W-1:0] vpn;
        logic [PTE_W-1:0] pte;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st        = ST_RD_REQ;
                    r_d.is_upd    = req_upd;
                    r_d.set_ref   = req_set_ref;
                    r_d.set_dirty = req_set_dirty;
                    r_d.base      = ptbr;
                    r_d.vpn       = req_vpn;
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) r_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.pte = mem_rsp_rdata;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!entry_present)  r_d.st = ST_FAULT;
                else if (r_q.is_upd) r_d.st = ST_WR_REQ;
                else                 r_d.st = ST_FILL;
            end
            ST_WR_REQ: begin
                if (mem_req_ready) r_d.st = ST_UPD_DONE;
            end
            ST_FILL, ST_FAULT, ST_UPD_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        base_q        = r_q.base;
        vpn_q         = r_q.vpn;
        pte_q         = r_q.pte;
        set_ref_q     = r_q.set_ref;
        set_dirty_q   = r_q.set_dirty;
        mem_req_valid = (r_q.st == ST_RD_REQ) || (r_q.st == ST_WR_REQ);
        mem_req_we    = (r_q.st == ST_WR_REQ);
        mem_req_wdata = merged_pte;
        busy          = (r_q.st != ST_IDLE);
        fill_valid    = (r_q.st == ST_FILL);
        fault_valid   = (r_q.st == ST_FAULT);
        upd_done      = (r_q.st == ST_UPD_DONE);
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(vpn_q)
             && $stable(base_q) && $stable(mem_req_wdata)));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(vpn_q) && $stable(base_q)));

    // R4
    fill_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> pte_q[PTE_PRES]);

    // R5
    fault_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !pte_q[PTE_PRES]);

    // R7
    wr_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[PTE_PRES]);

    // R8
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_valid, fault_valid, upd_done}));

    // R8
    outcome_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid || upd_done) |=> !busy);

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int PA_W        = 32,
    parameter int VPN_W       = 20,
    parameter int PPN_W       = 20,
    parameter int ENTRY_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    input  logic             req_upd,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_set_ref,
    input  logic             req_set_dirty,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [31:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_rdata,
    output logic             fill_valid,
    output logic             fault_valid,
    output logic             upd_done,
    output logic [VPN_W-1:0] out_vpn,
    output logic [31:0]      out_pte,
    output logic [PPN_W-1:0] out_ppn
);
    logic [PA_W-1:0]  base_w;
    logic [VPN_W-1:0] vpn_w;
    logic [PTE_W-1:0] pte_w;
    logic [PTE_W-1:0] merged_w;
    logic             present_w;
    logic             set_ref_w;
    logic             set_dirty_w;

    ptw_ctrl #(.PA_W(PA_W), .VPN_W(VPN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ptbr          (ptbr),
        .req_valid     (req_valid),
        .req_upd       (req_upd),
        .req_vpn       (req_vpn),
        .req_set_ref   (req_set_ref),
        .req_set_dirty (req_set_dirty),
        .entry_present (present_w),
        .merged_pte    (merged_w),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .base_q        (base_w),
        .vpn_q         (vpn_w),
        .pte_q         (pte_w),
        .set_ref_q     (set_ref_w),
        .set_dirty_q   (set_dirty_w),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_wdata (mem_req_wdata),
        .busy          (busy),
        .fill_valid    (fill_valid),
        .fault_valid   (fault_valid),
        .upd_done      (upd_done)
    );

    ptw_addr_gen #(.PA_W(PA_W), .VPN_W(VPN_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
        .base (base_w),
        .vpn  (vpn_w),
        .addr (mem_req_addr)
    );

    ptw_entry_dec #(.PPN_W(PPN_W)) u_dec (
        .pte       (pte_w),
        .set_ref   (set_ref_w),
        .set_dirty (set_dirty_w),
        .present   (present_w),
        .ppn       (out_ppn),
        .merged    (merged_w)
    );

    assign out_vpn = vpn_w;
    assign out_pte = pte_w;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !mem_req_valid && !fill_valid && !fault_valid && !upd_done));

endmodule

// File: tb/sim_ptw_engine.sv
`timescale 1ns/1ps
module sim_ptw_engine;
    localparam int PA_W  = 32;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PA_W-1:0]  ptbr = '0;
    logic             req_valid = 1'b0, req_upd = 1'b0, req_set_ref = 1'b0, req_set_dirty = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic             busy, mem_req_valid, mem_req_we, fill_valid, fault_valid, upd_done;
    logic             mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [PA_W-1:0]  mem_req_addr;
    logic [31:0]      mem_req_wdata, out_pte;
    logic [31:0]      mem_rsp_rdata = '0;
    logic [VPN_W-1:0] out_vpn;
    logic [PPN_W-1:0] out_ppn;

    always #2.5 clk = ~clk;

    ptw_engine #(.PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
        .req_valid(req_valid), .req_upd(req_upd), .req_vpn(req_vpn),
        .req_set_ref(req_set_ref), .req_set_dirty(req_set_dirty),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .fill_valid(fill_valid), .fault_valid(fault_valid), .upd_done(upd_done),
        .out_vpn(out_vpn), .out_pte(out_pte), .out_ppn(out_ppn)
    );

    typedef struct {
        int               kind;   // 0 fill, 1 fault, 2 update done
        logic [VPN_W-1:0] vpn;
        logic [31:0]      pte;
    } exp_t;

    exp_t             sbq[$];
    int               errors = 0, checks = 0;
    logic [31:0]      mem [256];
    logic [31:0]      exp_mem [256];
    int               stall_cfg = 0, lat_cfg = 1, rd_cnt = 0, wr_cnt = 0;
    logic [VPN_W-1:0] cur_vpn = '0;
    logic [31:0]      exp_wdata = '0;
    bit               chk_idle = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [PA_W-1:0] a);
        logic [PA_W-1:0] d;
        d = a - ptbr;
        return int'((d >> 2) & 255);
    endfunction

    // memory model
    initial begin
        int stall_left, rsp_left;
        logic [31:0] rsp_data;
        logic [PA_W-1:0] hold_addr, exp_addr;
        bit holding;
        stall_left = 0; rsp_left = 0; rsp_data = '0; hold_addr = '0; holding = 0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rsp_left > 0) begin
                rsp_left--;
                if (rsp_left == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rsp_data;
                end
            end
            if (rst_n && mem_req_valid) begin
                if (!holding) begin
                    holding = 1;
                    stall_left = stall_cfg;
                    hold_addr = mem_req_addr;
                    exp_addr = ptbr + (PA_W'(cur_vpn) << 2);
                    chk(mem_req_addr == exp_addr, "R2", "entry address", mem_req_addr, exp_addr);
                end else begin
                    chk(mem_req_addr == hold_addr, "R3", "held address", mem_req_addr, hold_addr);
                end
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                    holding = 0;
                    if (mem_req_we) begin
                        wr_cnt++;
                        chk(mem_req_wdata == exp_wdata, "R7", "write data", mem_req_wdata, exp_wdata);
                        mem[idx_of(mem_req_addr)] = mem_req_wdata;
                    end else begin
                        rd_cnt++;
                        rsp_left = lat_cfg;
                        rsp_data = mem[idx_of(mem_req_addr)];
                    end
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (chk_idle) begin
                chk(!busy, "R8", "busy after outcome", busy, 0);
                chk_idle = 0;
            end
            if (rst_n && (fill_valid || fault_valid || upd_done)) begin
                int k;
                k = fill_valid ? 0 : (fault_valid ? 1 : 2);
                chk_idle = 1;
                if (sbq.size() == 0) begin
                    chk(0, "R6", "unexpected outcome", k, 99);
                end else begin
                    exp_t e;
                    string tag;
                    e = sbq.pop_front();
                    tag = (e.kind == 0) ? "R4" : ((e.kind == 1) ? "R5" : "R7");
                    chk(k == e.kind, "R8", "outcome kind", k, e.kind);
                    chk(out_vpn == e.vpn, tag, "out_vpn", out_vpn, e.vpn);
                    if (k == 0 && e.kind == 0) begin
                        chk(out_pte == e.pte, "R4", "fill entry", out_pte, e.pte);
                        chk(out_ppn == e.pte[19:0], "R4", "fill ppn", out_ppn, e.pte[19:0]);
                    end
                end
            end
        end
    end

    task automatic run_op(input bit upd, input logic [VPN_W-1:0] vpn,
                          input bit sref, input bit sdirty, input bit stray);
        logic [31:0] old_e, new_e;
        int idx, exp_wr;
        exp_t e;
        do @(negedge clk); while (busy);
        rd_cnt = 0; wr_cnt = 0; cur_vpn = vpn;
        idx = int'(vpn & 255);
        old_e = exp_mem[idx];
        exp_wr = 0;
        e.vpn = vpn; e.pte = old_e;
        if (!old_e[31]) begin
            e.kind = 1;
        end else if (!upd) begin
            e.kind = 0;
        end else begin
            new_e = old_e | {1'b0, sref, sdirty, 29'b0};
            exp_mem[idx] = new_e;
            exp_wdata = new_e;
            e.kind = 2;
            exp_wr = 1;
        end
        sbq.push_back(e);
        req_valid = 1'b1; req_upd = upd; req_vpn = vpn;
        req_set_ref = sref; req_set_dirty = sdirty;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray) begin
            @(negedge clk);
            req_valid = 1'b1; req_upd = 1'b1; req_vpn = vpn ^ 20'h1;
            req_set_ref = 1'b1; req_set_dirty = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        do @(negedge clk); while (sbq.size() != 0 || busy);
        @(negedge clk);
        chk(rd_cnt == 1, "R9", "read count", rd_cnt, 1);
        chk(wr_cnt == exp_wr, "R9", "write count", wr_cnt, exp_wr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            if (i % 3 != 0) mem[i] = {1'b1, 2'b00, 9'(i * 7), 20'(i * 137 + 5)};
            else            mem[i] = {1'b0, 31'(i * 11 + 1)};
            exp_mem[i] = mem[i];
        end
        ptbr = 32'h0004_0000;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk(!busy && !mem_req_valid, "R1", "busy/mem in reset", {busy, mem_req_valid}, 0);
        chk(!fill_valid && !fault_valid && !upd_done, "R1", "outcomes in reset",
            {fill_valid, fault_valid, upd_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid, "R1", "after release", {busy, mem_req_valid}, 0);

        // plain walks, fast memory
        run_op(0, 20'd1, 0, 0, 0);   // R4 fill
        run_op(0, 20'd3, 0, 0, 0);   // R5 fault
        run_op(0, 20'd2, 0, 0, 0);
        // slow memory, stray request while busy (R3, R6)
        stall_cfg = 3; lat_cfg = 5;
        run_op(0, 20'd4, 0, 0, 1);
        run_op(0, 20'd6, 0, 0, 1);
        // updates (R7) accumulate, then read back by walks
        stall_cfg = 1; lat_cfg = 2;
        run_op(1, 20'd5, 1, 0, 0);
        run_op(0, 20'd5, 0, 0, 0);
        run_op(1, 20'd5, 0, 1, 1);
        run_op(0, 20'd5, 0, 0, 0);
        run_op(1, 20'd9, 1, 1, 0);   // absent: fault, no write
        run_op(1, 20'd7, 1, 1, 0);
        run_op(0, 20'd7, 0, 0, 0);
        // wrapping address, full-width page number (R2)
        ptbr = 32'hFFFF_F800; stall_cfg = 0; lat_cfg = 1;
        run_op(0, 20'hFFFFE, 0, 0, 0);
        run_op(0, 20'hFFFFF, 0, 0, 0);
        run_op(1, 20'hFFFFE, 0, 1, 0);
        run_op(0, 20'hFFFFE, 0, 0, 0);

        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
            chk(bad == 0, "R7", "table contents mismatches", bad, 0);
        end
        chk(sbq.size() == 0, "R8", "pending outcomes", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule